// File: doc/BRIEF.md
# Multiplexed Address/Data Memory Interface

This block is the bus controller between a small processor core's data-memory port and a set of external pins. Each access the core makes is classified by comparing its address against the top of internal memory. Accesses above that boundary become external bus cycles. One shared byte of pins first carries the low address and then carries data. A dedicated byte of pins carries the high address. An address latch enable (ALE) pulse tells an external transparent latch when to capture the low address. Active-low read and write strobes frame the data transfer.

While the block is enabled, it owns the bus pins: their direction and value come from the bus sequencer. Internal accesses still produce an ALE pulse and show the address on the pins, but no strobe is asserted for them. While the block is disabled, every pin follows its ordinary port output and direction registers. No external cycle is started in that mode, even for addresses above internal memory.

The sequencer has four states:
- `ST_IDLE`: waits for a request.
- `ST_ADDR`: address phase, ALE high.
- `ST_STROBE`: strobe phase, ALE low, lasting 1 + wait-state cycles.
- `ST_END`: strobes released and ready raised.

The transitions are:
- `ST_IDLE`→`ST_ADDR` on an accepted request while enabled.
- `ST_ADDR`→`ST_STROBE` always.
- `ST_STROBE`→`ST_STROBE` while wait states remain on an external cycle.
- `ST_STROBE`→`ST_END` when an external cycle's wait states are used up.
- `ST_STROBE`→`ST_IDLE` for an internal (shadow) cycle.
- `ST_END`→`ST_IDLE` always.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset, with the block enabled, ALE (control pin bit 0) is low, read strobe (bit 1) and write strobe (bit 2) are high, the shared byte is not driven, ready is low and rdata is 0.
- R2: An access is external when addr > INT_TOP (default 16'h10FF) and internal otherwise. For an internal access, ready is high in the same cycle as the request. For an external access, ready stays low in that cycle.
- R3: An accepted access has one ALE-high cycle, the cycle after the request edge. In that cycle the shared byte drives addr[7:0] with all its output enables set. ALE is low in the next cycle.
- R4: The high address byte carries addr[15:8] and is stable from the address phase to the end of the cycle. ALE stays low through the strobe and end phases.
- R5: On an external read, the read strobe is low during the strobe phase and the shared byte is not driven. The pin value present in the last strobe cycle appears on rdata from the end cycle on.
- R6: On an external write, the write strobe is low during the strobe phase. The shared byte drives wdata from the start of the strobe phase through the end cycle, which is one cycle after the write strobe rises.
- R7: The wait-state setting ws_cfg (0 to 3), sampled at the request, sets the strobe phase to ws_cfg+1 cycles. Ready is high for exactly the single cycle after the strobe phase.
- R8: While enabled, an internal access produces the ALE pulse and the address on the pins, but neither strobe ever goes low.
- R9: While enabled, the high-byte and control pins have every output enable set. Their values come from the bus sequencer, not from the port registers.
- R10: While disabled, every pad output and enable equals the matching port register. A request to an external address is answered with ready in the same cycle, produces no ALE or strobe, and leaves rdata unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Bus interface enable |
| ws_cfg | input | 2 | Wait-state count for external cycles |
| req | input | 1 | Core access request, held until ready |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Access address |
| wdata | input | 8 | Write data |
| ready | output | 1 | Access complete |
| rdata | output | 8 | Data captured from the last external read |
| port_lo_out | input | 8 | Normal port value, shared byte |
| port_lo_dir | input | 8 | Normal port direction, shared byte |
| port_hi_out | input | 8 | Normal port value, high byte |
| port_hi_dir | input | 8 | Normal port direction, high byte |
| port_ctl_out | input | 3 | Normal port value, control pins (ALE, read, write) |
| port_ctl_dir | input | 3 | Normal port direction, control pins |
| pad_ad_in | input | 8 | Shared byte pin input |
| pad_ad_out | output | 8 | Shared byte pin output |
| pad_ad_oe | output | 8 | Shared byte pin output enable |
| pad_hi_out | output | 8 | High byte pin output |
| pad_hi_oe | output | 8 | High byte pin output enable |
| pad_ctl_out | output | 3 | Control pin output: bit 0 ALE, bit 1 read strobe, bit 2 write strobe |
| pad_ctl_oe | output | 3 | Control pin output enable |

## Verification
Several properties are checked on every cycle:
- ALE is only ever a single-cycle pulse.
- The high address byte is stable through the strobe and end phases.
- The read strobe never overlaps a driven shared byte.
- No strobe goes low for an internal access.
- The strobe length matches the sampled wait-state count.
- The pin enables follow the enable mode.

Other behaviours depend on the values chosen at the ports, so only the directed scenarios show them: the exact address and data values on the pins, the captured read byte, the boundary between internal and external addresses, and the immediate ready in disabled mode.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_STROBE,
        ST_END
    } xb_state_e;

    localparam int CTL_ALE = 0;
    localparam int CTL_RD  = 1;
    localparam int CTL_WR  = 2;
    localparam int CTL_N   = 3;
endpackage

// File: rtl/xbus_fsm.sv
module xbus_fsm
    import xbus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int WSW = 2,
    parameter logic [AW-1:0] INT_TOP = 16'h10FF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [WSW-1:0] ws_cfg,
    input  logic          req,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] ad_in,
    output logic          ready,
    output logic [DW-1:0] rdata,
    output logic          bus_ale,
    output logic          bus_rd_n,
    output logic          bus_wr_n,
    output logic [DW-1:0] bus_ad_out,
    output logic          bus_ad_oe,
    output logic [AW-DW-1:0] bus_hi
);
    localparam int LENW = WSW + 1;

    xb_state_e state, state_nx;
    logic [WSW-1:0] ws_cnt, ws_q;
    logic [AW-1:0]  addr_q;
    logic [DW-1:0]  wdata_q, rdata_q;
    logic           we_q, ext_q;
    logic           ext_now, accept;

    assign ext_now = (addr > INT_TOP);
    assign accept  = (state == ST_IDLE) && req && en;

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (accept) state_nx = ST_ADDR;
            ST_ADDR:   state_nx = ST_STROBE;
            ST_STROBE: begin
                if (!ext_q)            state_nx = ST_IDLE;
                else if (ws_cnt == '0) state_nx = ST_END;
                else                   state_nx = ST_STROBE;
            end
            ST_END:    state_nx = ST_IDLE;
        endcase
    end

    // state register and cycle context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            ws_cnt  <= '0;
            ws_q    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            we_q    <= 1'b0;
            ext_q   <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept) begin
                addr_q  <= addr;
                we_q    <= we;
                wdata_q <= wdata;
                ext_q   <= ext_now;
                ws_cnt  <= ws_cfg;
                ws_q    <= ws_cfg;
            end
            if (state == ST_STROBE && ext_q) begin
                if (ws_cnt != '0) ws_cnt <= ws_cnt - 1'b1;
                else if (!we_q)   rdata_q <= ad_in;
            end
        end
    end

    // outputs
    always_comb begin
        bus_ale    = (state == ST_ADDR);
        bus_rd_n   = !((state == ST_STROBE) && ext_q && !we_q);
        bus_wr_n   = !((state == ST_STROBE) && ext_q && we_q);
        bus_ad_out = (state == ST_ADDR) ? addr_q[DW-1:0] : wdata_q;
        bus_ad_oe  = (state == ST_ADDR) ||
                     (((state == ST_STROBE) || (state == ST_END)) && we_q);
        bus_hi     = addr_q[AW-1:DW];
        ready      = ((state == ST_IDLE) && req && !(en && ext_now)) ||
                     (state == ST_END);
        rdata      = rdata_q;
    end

    // strobe-length tracking for the wait-state check
    logic [LENW-1:0] len_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     len_q <= '0;
        else if (!bus_rd_n || !bus_wr_n) len_q <= len_q + 1'b1;
        else                            len_q <= '0;
    end

    AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |=> !bus_ale); // R3
    AST_HI_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_STROBE) || (state == ST_END)) |-> $stable(bus_hi)); // R4
    AST_RD_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> !bus_ad_oe); // R5
    AST_INT_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != ST_IDLE) && !ext_q) |-> (bus_rd_n && bus_wr_n)); // R8
    AST_STROBE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_END) |-> (len_q == ({1'b0, ws_q} + 1'b1))); // R7
endmodule

// File: rtl/xbus_pinmux.sv
module xbus_pinmux
    import xbus_pkg::*;
#(
    parameter int DW = 8,
    parameter int HW = 8
) (
    input  logic             en,
    input  logic [DW-1:0]    bus_ad_out,
    input  logic             bus_ad_oe,
    input  logic [HW-1:0]    bus_hi,
    input  logic [CTL_N-1:0] bus_ctl,
    input  logic [DW-1:0]    port_lo_out,
    input  logic [DW-1:0]    port_lo_dir,
    input  logic [HW-1:0]    port_hi_out,
    input  logic [HW-1:0]    port_hi_dir,
    input  logic [CTL_N-1:0] port_ctl_out,
    input  logic [CTL_N-1:0] port_ctl_dir,
    output logic [DW-1:0]    pad_ad_out,
    output logic [DW-1:0]    pad_ad_oe,
    output logic [HW-1:0]    pad_hi_out,
    output logic [HW-1:0]    pad_hi_oe,
    output logic [CTL_N-1:0] pad_ctl_out,
    output logic [CTL_N-1:0] pad_ctl_oe
);
    for (genvar i = 0; i < DW; i++) begin : g_lo
        assign pad_ad_out[i] = en ? bus_ad_out[i] : port_lo_out[i];
        assign pad_ad_oe[i]  = en ? bus_ad_oe     : port_lo_dir[i];
    end
    for (genvar i = 0; i < HW; i++) begin : g_hi
        assign pad_hi_out[i] = en ? bus_hi[i] : port_hi_out[i];
        assign pad_hi_oe[i]  = en ? 1'b1      : port_hi_dir[i];
    end
    for (genvar i = 0; i < CTL_N; i++) begin : g_ctl
        assign pad_ctl_out[i] = en ? bus_ctl[i] : port_ctl_out[i];
        assign pad_ctl_oe[i]  = en ? 1'b1       : port_ctl_dir[i];
    end
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int WSW = 2,
    parameter logic [AW-1:0] INT_TOP = 16'h10FF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [WSW-1:0]     ws_cfg,
    input  logic               req,
    input  logic               we,
    input  logic [AW-1:0]      addr,
    input  logic [DW-1:0]      wdata,
    output logic               ready,
    output logic [DW-1:0]      rdata,
    input  logic [DW-1:0]      port_lo_out,
    input  logic [DW-1:0]      port_lo_dir,
    input  logic [AW-DW-1:0]   port_hi_out,
    input  logic [AW-DW-1:0]   port_hi_dir,
    input  logic [CTL_N-1:0]   port_ctl_out,
    input  logic [CTL_N-1:0]   port_ctl_dir,
    input  logic [DW-1:0]      pad_ad_in,
    output logic [DW-1:0]      pad_ad_out,
    output logic [DW-1:0]      pad_ad_oe,
    output logic [AW-DW-1:0]   pad_hi_out,
    output logic [AW-DW-1:0]   pad_hi_oe,
    output logic [CTL_N-1:0]   pad_ctl_out,
    output logic [CTL_N-1:0]   pad_ctl_oe
);
    localparam int HW = AW - DW;

    logic          bus_ale, bus_rd_n, bus_wr_n, bus_ad_oe;
    logic [DW-1:0] bus_ad_out;
    logic [HW-1:0] bus_hi;
    logic [CTL_N-1:0] bus_ctl;

    always_comb begin
        bus_ctl          = '1;
        bus_ctl[CTL_ALE] = bus_ale;
        bus_ctl[CTL_RD]  = bus_rd_n;
        bus_ctl[CTL_WR]  = bus_wr_n;
    end

    xbus_fsm #(.AW(AW), .DW(DW), .WSW(WSW), .INT_TOP(INT_TOP)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en), .ws_cfg(ws_cfg),
        .req(req), .we(we), .addr(addr), .wdata(wdata), .ad_in(pad_ad_in),
        .ready(ready), .rdata(rdata),
        .bus_ale(bus_ale), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_hi(bus_hi)
    );

    xbus_pinmux #(.DW(DW), .HW(HW)) u_pinmux (
        .en(en), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe),
        .bus_hi(bus_hi), .bus_ctl(bus_ctl),
        .port_lo_out(port_lo_out), .port_lo_dir(port_lo_dir),
        .port_hi_out(port_hi_out), .port_hi_dir(port_hi_dir),
        .port_ctl_out(port_ctl_out), .port_ctl_dir(port_ctl_dir),
        .pad_ad_out(pad_ad_out), .pad_ad_oe(pad_ad_oe),
        .pad_hi_out(pad_hi_out), .pad_hi_oe(pad_hi_oe),
        .pad_ctl_out(pad_ctl_out), .pad_ctl_oe(pad_ctl_oe)
    );

    AST_EN_OWNS_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> ((&pad_hi_oe) && (&pad_ctl_oe))); // R9
    AST_DIS_FOLLOWS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> ((pad_ctl_oe == port_ctl_dir) && (pad_ctl_out == port_ctl_out))); // R10
endmodule

// File: tb/xbus_ctrl_test.sv
module xbus_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b1;
    logic [1:0]  ws_cfg = '0;
    logic        req = 1'b0, we = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        ready;
    logic [7:0]  rdata;
    logic [7:0]  port_lo_out = '0, port_lo_dir = '0, port_hi_out = '0, port_hi_dir = '0;
    logic [2:0]  port_ctl_out = '0, port_ctl_dir = '0;
    logic [7:0]  pad_ad_in = '0;
    logic [7:0]  pad_ad_out, pad_ad_oe, pad_hi_out, pad_hi_oe;
    logic [2:0]  pad_ctl_out, pad_ctl_oe;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    xbus_ctrl uut (
        .clk(clk), .rst_n(rst_n), .en(en), .ws_cfg(ws_cfg), .req(req), .we(we),
        .addr(addr), .wdata(wdata), .ready(ready), .rdata(rdata),
        .port_lo_out(port_lo_out), .port_lo_dir(port_lo_dir),
        .port_hi_out(port_hi_out), .port_hi_dir(port_hi_dir),
        .port_ctl_out(port_ctl_out), .port_ctl_dir(port_ctl_dir),
        .pad_ad_in(pad_ad_in), .pad_ad_out(pad_ad_out), .pad_ad_oe(pad_ad_oe),
        .pad_hi_out(pad_hi_out), .pad_hi_oe(pad_hi_oe),
        .pad_ctl_out(pad_ctl_out), .pad_ctl_oe(pad_ctl_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic t_reset();
        chk("R1 ale", pad_ctl_out[0], 1'b0);
        chk("R1 rd_n", pad_ctl_out[1], 1'b1);
        chk("R1 wr_n", pad_ctl_out[2], 1'b1);
        chk("R1 ad_oe", pad_ad_oe, 8'h00);
        chk("R1 ready", ready, 1'b0);
        chk("R1 rdata", rdata, 8'h00);
        chk("R9 hi_oe", pad_hi_oe, 8'hFF);
        chk("R9 ctl_oe", pad_ctl_oe, 3'b111);
    endtask

    task automatic t_ext_read(input logic [15:0] a, input logic [1:0] ws, input logic [7:0] d);
        step();
        addr = a; we = 1'b0; ws_cfg = ws; req = 1'b1; pad_ad_in = d; #1;
        chk("R2 ext no early ready", ready, 1'b0);
        step();
        chk("R3 ale high", pad_ctl_out[0], 1'b1);
        chk("R3 ad addr lo", pad_ad_out, {24'h0, a[7:0]});
        chk("R3 ad oe", pad_ad_oe, 8'hFF);
        chk("R4 hi addr", pad_hi_out, {24'h0, a[15:8]});
        for (int k = 0; k <= ws; k++) begin
            step();
            chk("R4 ale low", pad_ctl_out[0], 1'b0);
            chk("R5 rd low", pad_ctl_out[1], 1'b0);
            chk("R5 ad released", pad_ad_oe, 8'h00);
            chk("R7 no ready in strobe", ready, 1'b0);
            chk("R4 hi held", pad_hi_out, {24'h0, a[15:8]});
        end
        step();
        chk("R7 rd released", pad_ctl_out[1], 1'b1);
        chk("R7 ready", ready, 1'b1);
        chk("R5 rdata", rdata, {24'h0, d});
        req = 1'b0;
        step();
        chk("R7 ready one cycle", ready, 1'b0);
        pad_ad_in = 8'h00;
    endtask

    task automatic t_ext_write(input logic [15:0] a, input logic [1:0] ws, input logic [7:0] d);
        step();
        addr = a; we = 1'b1; ws_cfg = ws; wdata = d; req = 1'b1;
        step();
        chk("R3 ale high", pad_ctl_out[0], 1'b1);
        chk("R3 ad addr lo", pad_ad_out, {24'h0, a[7:0]});
        for (int k = 0; k <= ws; k++) begin
            step();
            chk("R6 wr low", pad_ctl_out[2], 1'b0);
            chk("R6 rd high", pad_ctl_out[1], 1'b1);
            chk("R6 data out", pad_ad_out, {24'h0, d});
            chk("R6 data oe", pad_ad_oe, 8'hFF);
        end
        step();
        chk("R6 wr released", pad_ctl_out[2], 1'b1);
        chk("R6 data held", pad_ad_out, {24'h0, d});
        chk("R6 data oe held", pad_ad_oe, 8'hFF);
        chk("R7 ready", ready, 1'b1);
        req = 1'b0; we = 1'b0;
        step();
        chk("R7 ready one cycle", ready, 1'b0);
    endtask

    task automatic t_int_access(input logic [15:0] a, input logic w);
        step();
        addr = a; we = w; wdata = 8'h3C; req = 1'b1; #1;
        chk("R2 int ready immediate", ready, 1'b1);
        step();
        req = 1'b0; #1;
        chk("R8 ale pulse", pad_ctl_out[0], 1'b1);
        chk("R8 addr shown", pad_ad_out, {24'h0, a[7:0]});
        step();
        chk("R8 rd stays high", pad_ctl_out[1], 1'b1);
        chk("R8 wr stays high", pad_ctl_out[2], 1'b1);
        chk("R8 ale low", pad_ctl_out[0], 1'b0);
        step();
        chk("R8 no late ready", ready, 1'b0);
        chk("R8 strobes idle", pad_ctl_out[2:1], 2'b11);
        we = 1'b0;
    endtask

    task automatic t_disabled();
        logic [7:0] rd_before;
        step();
        rd_before = rdata;
        en = 1'b0;
        port_lo_out = 8'hA5; port_lo_dir = 8'h0F;
        port_hi_out = 8'h5A; port_hi_dir = 8'hF0;
        port_ctl_out = 3'b010; port_ctl_dir = 3'b101; #1;
        chk("R10 lo out", pad_ad_out, 8'hA5);
        chk("R10 lo dir", pad_ad_oe, 8'h0F);
        chk("R10 hi out", pad_hi_out, 8'h5A);
        chk("R10 hi dir", pad_hi_oe, 8'hF0);
        chk("R10 ctl", {pad_ctl_out, pad_ctl_oe}, {3'b010, 3'b101});
        addr = 16'hC000; we = 1'b0; req = 1'b1; pad_ad_in = 8'hEE; #1;
        chk("R10 ext ready immediate", ready, 1'b1);
        step();
        req = 1'b0;
        step();
        chk("R10 no cycle ctl", pad_ctl_out, 3'b010);
        chk("R10 rdata unchanged", rdata, {24'h0, rd_before});
        en = 1'b1; #1;
        chk("R9 override back", pad_hi_oe, 8'hFF);
        chk("R9 ctl driven by bus", pad_ctl_out, 3'b110);
        pad_ad_in = 8'h00;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #1;
        t_reset();
        t_ext_read(16'h1100, 2'd0, 8'h96);    // first external address
        t_ext_read(16'hBEEF, 2'd3, 8'h4B);
        t_ext_write(16'h8001, 2'd0, 8'hC3);
        t_ext_write(16'hFFFF, 2'd2, 8'h71);
        t_int_access(16'h10FF, 1'b0);         // boundary is internal
        t_int_access(16'h0042, 1'b1);
        t_ext_read(16'h2345, 2'd1, 8'h18);
        t_disabled();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule